// File: doc/BRIEF.md
# Strobed Input Port Interrupt Unit

This block serves two 8-bit bidirectional ports. Each has an input data register that captures the pins on a strobe, plus an interrupt flag. The block drives one active-low, open-drain interrupt request. Each port's capture signal is its strobe pin XORed with a software polarity bit. While the capture signal is low, the data register follows the pins. On a rising edge of the capture signal, the data register freezes and the port's flag is set. A rising edge caused by writing the polarity bit alone therefore latches data and raises a software interrupt.

The strobes pass through a two-flop synchronizer, and all capture logic runs in the single system clock domain. A host register interface sets:
- the direction of each port;
- the strobe polarity of each port;
- the interrupt enables;
- the flag clearing mode.

The host also reads the captured data and the status. A third interrupt source, a write-cycle-complete indication from outside the block, enters as an input with its own enable.

Register map (`addr`):
- 0 is port A data.
- 1 is port B data.
- 2 is control: bit0 A is output, bit1 B is output, bit2 A polarity, bit3 B polarity, bit4 clear mode.
- 3 is status: bit0 A flag, bit1 B flag, bit2 A enable, bit3 B enable, bit4 write-complete enable, bit5 write-complete input (read only).

Top module: `strobe_port_irq`

## Requirements
- R1: After reset, control reads 0x00 and status reads 0x00. `irq_oe`, `pa_oe` and `pb_oe` are 0.
- R2: While a port is an input and its capture signal (synchronized strobe XOR polarity bit) is low, reading its data register (addr 0 or 1) returns the current pin value.
- R3: A 0-to-1 change of a port's capture signal caused by the strobe pin freezes the data register at the pin value from before the edge. It also sets the port's status flag, visible no later than three clocks after the pin change. A 1-to-0 change sets no flag.
- R4: Writing the polarity bit (control bit2 for A, bit3 for B) so that the capture signal rises has the same effect, with no strobe activity. The flag shows on the clock after the write.
- R5: A port whose control direction bit is 1 never sets its flag. It drives the last value written to its data address on its output pins with its output enable at 1, and reading its data address returns that value.
- R6: `irq_oe` is 1 exactly when a flag is 1 together with its enable; the write-complete input counts as a flag. This includes an enable written while the flag is already set, and `irq_oe` stays at 1 until the flag or the enable is cleared. The line is never driven high.
- R7: With control bit4 = 1, writing 0 to status bit0 or bit1 clears that flag. Writing 1 leaves it unchanged, and data reads do not clear flags.
- R8: With control bit4 = 0, reading a port's data address clears only that port's flag. Writes to the status flag bits have no effect on flags.
- R9: When a capture edge and a clear event hit the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| stb_a | input | 1 | Port A strobe pin (asynchronous) |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| stb_b | input | 1 | Port B strobe pin (asynchronous) |
| wc_done | input | 1 | Write-cycle-complete flag from outside |
| irq_oe | output | 1 | Pull interrupt line low when 1 |

## Verification
The hardest case to reach is R9, a capture edge and a flag clear landing on the same clock. The edge reaches the flag only after the two synchronizer stages. The stimulus raises the strobe pin at a falling clock edge and counts two rising edges. It then presents the write-zero-to-clear on the following cycle, so both events meet at one register update. Software-generated captures through the polarity bit are also awkward, because the previous capture level must be known. The sequence therefore toggles the polarity away and back while the strobe is held.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int NPORT    = 2;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_PORTA = 2'd0;
    localparam logic [ADDR_W-1:0] A_PORTB = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

    // control layout: {mode, pol[1:0], dir[1:0]}
    typedef struct packed {
        logic             mode;
        logic [NPORT-1:0] pol;
        logic [NPORT-1:0] dir;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else if (s == 0) chain_q[s] <= d;
                else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sport_lane.sv
module sport_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pin_in,
    input  logic          strobe_raw,
    input  logic          pol,
    input  logic          dir_out,
    input  logic          out_wr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_evt,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] out_q,
    output logic          flag_q
);
    typedef struct packed {
        logic          cap;
        logic [DW-1:0] data;
        logic [DW-1:0] outl;
        logic          flag;
    } lane_t;

    lane_t st_d, st_q;
    logic  stb_s;
    logic  cap;
    logic  rise;

    sport_sync #(.W(1), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe_raw),
        .q     (stb_s)
    );

    always_comb begin
        cap  = stb_s ^ pol;
        rise = cap & ~st_q.cap;
        st_d = st_q;
        st_d.cap = cap;
        if (!cap) st_d.data = pin_in;
        if (out_wr) st_d.outl = wdata;
        if (clr_evt) st_d.flag = 1'b0;
        if (rise && !dir_out) st_d.flag = 1'b1;   // set wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign out_q  = st_q.outl;
    assign flag_q = st_q.flag;

    // capture edge on an input port sets the flag, even against a clear (R3, R4, R9)
    p_edge_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && cap && !st_q.cap) |=> flag_q);

    // output port cannot raise a flag (R5)
    p_out_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && !flag_q) |=> !flag_q);

    // transparent while capture level low (R2)
    p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap) |=> (data_q == $past(pin_in)));

    // frozen while capture level high (R3)
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> $stable(data_q));
endmodule

// File: rtl/strobe_port_irq.sv
module strobe_port_irq
    import sport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic              pa_oe,
    input  logic              stb_a,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic              pb_oe,
    input  logic              stb_b,
    input  logic              wc_done,
    output logic              irq_oe
);
    localparam int EN_W = NPORT + 1;

    typedef struct packed {
        ctl_t            ctl;
        logic [EN_W-1:0] en;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [DW-1:0]    pin_arr  [NPORT];
    logic [DW-1:0]    data_arr [NPORT];
    logic [DW-1:0]    out_arr  [NPORT];
    logic [NPORT-1:0] stb_arr;
    logic [NPORT-1:0] flag;
    logic [NPORT-1:0] clr_evt;
    logic [NPORT-1:0] out_wr;
    logic             stat_wr;

    assign pin_arr[0] = pa_in;
    assign pin_arr[1] = pb_in;
    assign stb_arr    = {stb_b, stb_a};
    assign stat_wr    = wr_en && (addr == A_STAT);

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_lane
            always_comb begin
                out_wr[i]  = wr_en && (addr == ADDR_W'(i));
                clr_evt[i] = rg_q.ctl.mode ? (stat_wr && !wdata[i])
                                           : (rd_en && (addr == ADDR_W'(i)));
            end

            sport_lane #(.DW(DW)) u_lane (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_in     (pin_arr[i]),
                .strobe_raw (stb_arr[i]),
                .pol        (rg_q.ctl.pol[i]),
                .dir_out    (rg_q.ctl.dir[i]),
                .out_wr     (out_wr[i]),
                .wdata      (wdata),
                .clr_evt    (clr_evt[i]),
                .data_q     (data_arr[i]),
                .out_q      (out_arr[i]),
                .flag_q     (flag[i])
            );

            // interrupt persists while flag and enable stay (R6)
            p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && rg_q.en[i] && !clr_evt[i] && !stat_wr) |=> irq_oe);

            // mode 0: status writes never clear a flag (R8)
            p_mode0_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!rg_q.ctl.mode && stat_wr && flag[i] && !rd_en) |=> flag[i]);
        end
    endgenerate

    always_comb begin
        rg_d = rg_q;
        if (wr_en && addr == A_CTRL) rg_d.ctl = ctl_t'(wdata[CTL_W-1:0]);
        if (stat_wr)                 rg_d.en  = wdata[NPORT +: EN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PORTA: rdata = rg_q.ctl.dir[0] ? out_arr[0] : data_arr[0];
            A_PORTB: rdata = rg_q.ctl.dir[1] ? out_arr[1] : data_arr[1];
            A_CTRL:  rdata[CTL_W-1:0] = rg_q.ctl;
            default: rdata[NPORT+EN_W:0] = {wc_done, rg_q.en, flag};
        endcase
    end

    assign irq_oe = |({wc_done, flag} & rg_q.en);
    assign pa_out = out_arr[0];
    assign pb_out = out_arr[1];
    assign pa_oe  = rg_q.ctl.dir[0];
    assign pb_oe  = rg_q.ctl.dir[1];

    // write-complete source gated by its enable (R6)
    p_wc_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_done && rg_q.en[NPORT] && !stat_wr) |=> (irq_oe || !wc_done));
endmodule

// File: tb/sim_strobe_port_irq.sv
module sim_strobe_port_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pa_out, pb_in = '0, pb_out;
    logic       pa_oe, pb_oe, irq_oe;
    logic       stb_a = 1'b0, stb_b = 1'b0, wc_done = 1'b0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    strobe_port_irq u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .stb_a(stb_a), .pb_in(pb_in), .pb_out(pb_out),
        .pb_oe(pb_oe), .stb_b(stb_b), .wc_done(wc_done), .irq_oe(irq_oe)
    );

    // entry: {kind, addr, data, expect, req}; kind 0 write, 1 read+check, 2 pins, 3 wait
    localparam int NV = 43;
    localparam logic [23:0] VEC [NV] = '{
        {2'd2,2'd0,8'h3C,8'h00,4'd2},  // pins A
        {2'd1,2'd0,8'h00,8'h3C,4'd2},  // R2 transparent
        {2'd1,2'd3,8'h00,8'h00,4'd2},
        {2'd0,2'd3,8'h04,8'h00,4'd6},  // enable A
        {2'd2,2'd2,8'h01,8'h00,4'd3},  // strobe A high
        {2'd1,2'd3,8'h00,8'h05,4'd3},  // R3 flag set
        {2'd2,2'd0,8'hA5,8'h00,4'd3},
        {2'd1,2'd0,8'h00,8'h3C,4'd3},  // R3 frozen, clears (R8)
        {2'd1,2'd3,8'h00,8'h04,4'd8},
        {2'd2,2'd2,8'h00,8'h00,4'd2},  // strobe low
        {2'd1,2'd0,8'h00,8'hA5,4'd2},
        {2'd0,2'd2,8'h04,8'h00,4'd4},  // polarity A -> software capture
        {2'd3,2'd0,8'h02,8'h00,4'd4},
        {2'd1,2'd3,8'h00,8'h05,4'd4},  // R4
        {2'd0,2'd3,8'h04,8'h00,4'd8},  // zero write ignored in mode 0
        {2'd1,2'd3,8'h00,8'h05,4'd8},
        {2'd2,2'd0,8'h11,8'h00,4'd4},
        {2'd1,2'd0,8'h00,8'hA5,4'd4},
        {2'd1,2'd3,8'h00,8'h04,4'd8},
        {2'd0,2'd2,8'h14,8'h00,4'd7},  // mode 1
        {2'd0,2'd2,8'h10,8'h00,4'd7},
        {2'd0,2'd2,8'h14,8'h00,4'd7},
        {2'd3,2'd0,8'h02,8'h00,4'd7},
        {2'd1,2'd0,8'h00,8'h11,4'd7},
        {2'd1,2'd3,8'h00,8'h05,4'd7},  // R7 read does not clear
        {2'd0,2'd3,8'h05,8'h00,4'd7},
        {2'd1,2'd3,8'h00,8'h05,4'd7},  // R7 write 1 keeps
        {2'd0,2'd3,8'h04,8'h00,4'd7},
        {2'd1,2'd3,8'h00,8'h04,4'd7},  // R7 write 0 clears
        {2'd0,2'd2,8'h12,8'h00,4'd5},  // B output
        {2'd0,2'd1,8'h5A,8'h00,4'd5},
        {2'd1,2'd1,8'h00,8'h5A,4'd5},  // R5
        {2'd0,2'd3,8'h0C,8'h00,4'd5},
        {2'd2,2'd2,8'h02,8'h00,4'd5},  // strobe B while output
        {2'd1,2'd3,8'h00,8'h0C,4'd5},
        {2'd0,2'd2,8'h10,8'h00,4'd5},
        {2'd3,2'd0,8'h02,8'h00,4'd5},
        {2'd1,2'd3,8'h00,8'h0C,4'd5},
        {2'd2,2'd2,8'h00,8'h00,4'd3},  // falling capture: no flag
        {2'd1,2'd3,8'h00,8'h0C,4'd3},
        {2'd0,2'd2,8'h18,8'h00,4'd4},  // polarity B
        {2'd3,2'd0,8'h02,8'h00,4'd4},
        {2'd1,2'd3,8'h00,8'h0E,4'd4}
    };

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdchk(input int req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, {5'd0, irq_oe, pb_oe, pa_oe}, 8'h00);
        rdchk(1, 2'd2, 8'h00);
        rdchk(1, 2'd3, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k, a;
            logic [7:0] d, e;
            {k, a, d, e} = VEC[i][23:4];
            case (k)
                2'd0: wr(a, d);
                2'd1: rdchk(int'(VEC[i][3:0]), a, e);
                2'd2: begin
                    if (a == 2'd0) pa_in = d;
                    else if (a == 2'd1) pb_in = d;
                    else {stb_b, stb_a} = d[1:0];
                    repeat (4) @(negedge clk);
                end
                default: repeat (int'(d)) @(negedge clk);
            endcase
        end

        // R6: flag B set with enable
        chk(6, {7'd0, irq_oe}, 8'h01);
        wr(2'd3, 8'h02);                       // drop enables, keep flag
        chk(6, {7'd0, irq_oe}, 8'h00);
        rdchk(6, 2'd3, 8'h02);
        wr(2'd3, 8'h0A);                       // enable after flag
        chk(6, {7'd0, irq_oe}, 8'h01);
        wr(2'd3, 8'h10);                       // clear B, enable write-complete
        chk(6, {7'd0, irq_oe}, 8'h00);
        wc_done = 1'b1; #1;
        chk(6, {7'd0, irq_oe}, 8'h01);
        rdchk(6, 2'd3, 8'h30);
        wc_done = 1'b0; #1;
        chk(6, {7'd0, irq_oe}, 8'h00);

        // R9: capture edge and write-zero clear in the same cycle
        wr(2'd3, 8'h04);
        stb_a = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        addr = 2'd3; wdata = 8'h04; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        rdchk(9, 2'd3, 8'h05);
        chk(9, {7'd0, irq_oe}, 8'h01);

        // R8: clear-on-read only affects its own port
        wr(2'd2, 8'h08);
        rdchk(8, 2'd1, 8'h00);
        rdchk(8, 2'd3, 8'h05);
        rdchk(8, 2'd0, 8'h11);
        rdchk(8, 2'd3, 8'h04);

        // R5: output drive
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hC3);
        chk(5, pa_out, 8'hC3);
        chk(5, {6'd0, pb_oe, pa_oe}, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule